// File: doc/BRIEF.md
# Dual-Domain Bus Clock Generator

This block derives two bus clocks from a single master clock. The slow bus clock is a fixed divider output with a 14-master-cycle period and a 50% duty cycle. Its inverse is provided alongside it. The fast bus clock drives the processor side. Its period is chosen one cycle at a time by a cycle-type request.

Each fast cycle opens with a two-cycle low phase. The length of the high phase depends on the cycle type:
- A normal cycle is high for three master cycles.
- A refresh cycle is high for eight master cycles.
- A synchronization cycle is used when the processor must meet the slow bus. It first completes the normal three-cycle high phase. It then holds the clock high until the slow clock next rises, follows the slow clock through its whole seven-cycle high phase, and falls together with it.

Alignment comes only from stretching the clock. No ready or wait handshake is involved.

The request is a plain control input, not a stream. The block samples it on the master edge that starts each fast cycle and ignores it at every other time. A one-cycle strobe marks each cycle start. An encoded output reports which kind of cycle is running.

Top module: `bus_clock_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high), the block holds its reset state. In the first master cycle after reset release, `fast_clk`, `slow_clk` and `cyc_start` read as follows: `fast_clk` is 0, `slow_clk` is 0, `slow_clk_n` is 1, `cyc_start` is 1 and `cyc_kind` is 0.
- R2: `slow_clk` is low for 7 master cycles and then high for 7, repeating with a 14-cycle period counted from reset release.
- R3: `slow_clk_n` is always the inverse of `slow_clk`.
- R4: A normal cycle (request code 2'b00) keeps `fast_clk` low for 2 master cycles and then high for 3.
- R5: A refresh cycle (request code 2'b01) keeps `fast_clk` low for 2 master cycles and then high for 8.
- R6: A synchronization cycle (request code 2'b10) keeps `fast_clk` low for 2 cycles and then high for 3 cycles. It then stays high until `slow_clk` rises, stays high through the 7 cycles that `slow_clk` is high, and falls on the same edge as `slow_clk`.
- R7: If `slow_clk` rises on the same edge at which the 3-cycle high phase of a synchronization cycle ends, the extension is zero and the high phase lasts exactly 10 cycles.
- R8: `cyc_start` is high for exactly the first master cycle of every fast cycle. The request is sampled only on the edge that begins a fast cycle. `cyc_kind` shows the type of the running cycle (0 normal, 1 refresh, 2 sync) and holds that value for the whole cycle.
- R9: Request code 2'b11 starts a normal cycle and is reported as `cyc_kind` 0.
- R10: The first fast cycle after reset is a normal cycle whatever the request input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | input | 2 | Requested type of the next fast cycle |
| slow_clk | output | 1 | Slow bus clock, 14-cycle period |
| slow_clk_n | output | 1 | Inverse of slow_clk |
| fast_clk | output | 1 | Fast processor bus clock |
| cyc_start | output | 1 | High in the first master cycle of each fast cycle |
| cyc_kind | output | 2 | Type of the fast cycle in progress |

## Verification
Normal and refresh cycles are interleaved so that each high-phase length is observed next to the other. This shows that the cycle type is taken from the request latched at cycle start, not from the request currently on the input.

Synchronization cycles are started at several offsets within the slow period, chosen so that the stretch is:
- zero, which catches an off-by-one in the alignment point;
- thirteen, the longest possible stretch;
- begun while the slow clock is already high, where the block must wait through that high phase and the following low phase rather than lock on at once.

The reserved request code, a sync request held during reset, and a reset in mid-run test the decode path and the restart of the slow phase count.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [1:0] {
    CK_NORMAL  = 2'd0,
    CK_REFRESH = 2'd1,
    CK_SYNC    = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    FS_LOW,
    FS_HIGH,
    FS_WAIT,
    FS_TRACK
  } fast_st_e;

  // Request code to cycle type; the reserved code falls back to normal.
  function automatic cyc_kind_e decode_req(input logic [1:0] code);
    cyc_kind_e k;
    case (code)
      2'b01:   k = CK_REFRESH;
      2'b10:   k = CK_SYNC;
      default: k = CK_NORMAL;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/bcg_slow_div.sv
module bcg_slow_div #(
  parameter int LO_CYCLES = 7,
  parameter int HI_CYCLES = 7
) (
  input  logic clk,
  input  logic rst,
  output logic slow_clk,
  output logic slow_clk_n,
  output logic rise_next,
  output logic fall_next
);
  localparam int PERIOD = LO_CYCLES + HI_CYCLES;
  localparam int SW     = $clog2(PERIOD);
  localparam logic [SW-1:0] LAST_CNT = SW'(PERIOD - 1);
  localparam logic [SW-1:0] HI_START = SW'(LO_CYCLES);
  localparam logic [SW-1:0] LO_LAST  = SW'(LO_CYCLES - 1);

  logic [SW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (phase_q == LAST_CNT) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  always_comb begin
    slow_clk   = (phase_q >= HI_START);
    slow_clk_n = ~slow_clk;
    rise_next  = (phase_q == LO_LAST);
    fall_next  = (phase_q == LAST_CNT);
  end

  // R2: once the slow clock has risen it is still high one cycle later.
  assert_slow_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_clk) |=> slow_clk);

endmodule

// File: rtl/bcg_fast_seq.sv
module bcg_fast_seq
  import bcg_pkg::*;
#(
  parameter int LO_CYCLES   = 2,
  parameter int HI_NORMAL   = 3,
  parameter int HI_REFRESH  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cyc_req,
  input  logic       slow_clk_i,
  input  logic       slow_rise_next,
  input  logic       slow_fall_next,
  output logic       fast_clk,
  output logic       cyc_start,
  output logic [1:0] cyc_kind
);
  localparam int MAXC = (HI_REFRESH > HI_NORMAL) ?
                        ((HI_REFRESH > LO_CYCLES) ? HI_REFRESH : LO_CYCLES) :
                        ((HI_NORMAL > LO_CYCLES) ? HI_NORMAL : LO_CYCLES);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LO_LAST  = CW'(LO_CYCLES - 1);
  localparam logic [CW-1:0] NRM_LAST = CW'(HI_NORMAL - 1);
  localparam logic [CW-1:0] REF_LAST = CW'(HI_REFRESH - 1);

  fast_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  cyc_kind_e       kind_q, kind_d;
  logic [CW-1:0]   hi_last;

  always_comb begin
    hi_last = (kind_q == CK_REFRESH) ? REF_LAST : NRM_LAST;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    case (st_q)
      FS_LOW: begin
        if (cnt_q == LO_LAST) begin
          st_d  = FS_HIGH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FS_HIGH: begin
        if (cnt_q == hi_last) begin
          cnt_d = '0;
          if (kind_q == CK_SYNC) begin
            st_d = slow_rise_next ? FS_TRACK : FS_WAIT;
          end else begin
            st_d   = FS_LOW;
            kind_d = decode_req(cyc_req);
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FS_WAIT: begin
        if (slow_rise_next) begin
          st_d = FS_TRACK;
        end
      end
      FS_TRACK: begin
        if (slow_fall_next) begin
          st_d   = FS_LOW;
          cnt_d  = '0;
          kind_d = decode_req(cyc_req);
        end
      end
      default: begin
        st_d  = FS_LOW;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_LOW;
      cnt_q  <= '0;
      kind_q <= CK_NORMAL;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  always_comb begin
    fast_clk  = (st_q != FS_LOW);
    cyc_start = (st_q == FS_LOW) && (cnt_q == '0);
    cyc_kind  = kind_q;
  end

  // R6: while locked to the slow clock, the slow clock is high.
  assert_track_high_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_TRACK) |-> slow_clk_i);

  // R6: a sync cycle ends on the same edge as the slow clock falls.
  assert_fall_together_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(fast_clk) && ($past(kind_q) == CK_SYNC)) |-> $fell(slow_clk_i));

  // R8: the start strobe lasts one master cycle.
  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start);

  // R8: the cycle type only changes when a new cycle starts.
  assert_kind_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |-> $stable(kind_q));

endmodule

// File: rtl/bus_clock_gen.sv
module bus_clock_gen #(
  parameter int SLOW_LO    = 7,
  parameter int SLOW_HI    = 7,
  parameter int FAST_LO    = 2,
  parameter int FAST_HI    = 3,
  parameter int FAST_HI_RF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cyc_req,
  output logic       slow_clk,
  output logic       slow_clk_n,
  output logic       fast_clk,
  output logic       cyc_start,
  output logic [1:0] cyc_kind
);
  logic rise_next;
  logic fall_next;

  bcg_slow_div #(
    .LO_CYCLES (SLOW_LO),
    .HI_CYCLES (SLOW_HI)
  ) u_slow (
    .clk        (clk),
    .rst        (rst),
    .slow_clk   (slow_clk),
    .slow_clk_n (slow_clk_n),
    .rise_next  (rise_next),
    .fall_next  (fall_next)
  );

  bcg_fast_seq #(
    .LO_CYCLES  (FAST_LO),
    .HI_NORMAL  (FAST_HI),
    .HI_REFRESH (FAST_HI_RF)
  ) u_fast (
    .clk            (clk),
    .rst            (rst),
    .cyc_req        (cyc_req),
    .slow_clk_i     (slow_clk),
    .slow_rise_next (rise_next),
    .slow_fall_next (fall_next),
    .fast_clk       (fast_clk),
    .cyc_start      (cyc_start),
    .cyc_kind       (cyc_kind)
  );

  // R9: the reserved code never appears as a running cycle type.
  assert_no_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    cyc_kind != 2'b11);

endmodule

// File: tb/bus_clock_gen_test.sv
`timescale 1ns/1ps
module bus_clock_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cyc_req = 2'b10;
  logic       slow_clk, slow_clk_n, fast_clk, cyc_start;
  logic [1:0] cyc_kind;

  int checks = 0;
  int fails  = 0;
  int k = 0;
  int pend_kind = 0;

  always #10 clk = ~clk;

  bus_clock_gen uut (
    .clk(clk), .rst(rst), .cyc_req(cyc_req),
    .slow_clk(slow_clk), .slow_clk_n(slow_clk_n),
    .fast_clk(fast_clk), .cyc_start(cyc_start), .cyc_kind(cyc_kind)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0d)", req, what, act, exp, k);
    end
  endtask

  function automatic int dec(input logic [1:0] r);
    return (r == 2'b01) ? 1 : ((r == 2'b10) ? 2 : 0);
  endfunction

  // One master cycle later, sampled away from the active edge.
  task automatic step();
    @(negedge clk);
    k++;
    check(slow_clk === ((k % 14) >= 7), "R2", "slow_clk phase",
          int'(slow_clk), int'((k % 14) >= 7));
    check(slow_clk_n === ~slow_clk, "R3", "slow_clk_n inverse",
          int'(slow_clk_n), int'(~slow_clk));
  endtask

  task automatic do_reset(input logic [1:0] req_in_reset);
    cyc_req = req_in_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    k = 0;
    pend_kind = 0;
    #1;
    check(fast_clk === 1'b0, "R1", "fast_clk after reset", int'(fast_clk), 0);
    check(slow_clk === 1'b0, "R1", "slow_clk after reset", int'(slow_clk), 0);
    check(slow_clk_n === 1'b1, "R1", "slow_clk_n after reset", int'(slow_clk_n), 1);
    check(cyc_start === 1'b1, "R1", "cyc_start after reset", int'(cyc_start), 1);
    check(cyc_kind === 2'd0, "R1", "cyc_kind after reset", int'(cyc_kind), 0);
  endtask

  // Runs the fast cycle starting at the current sample; next_req is
  // presented for the following cycle.
  task automatic run_cycle(input logic [1:0] next_req, input string tag);
    int k0, lo, hi, exp_hi, m, cur;
    logic [63:0] sv;
    k0 = k;
    cur = pend_kind;
    check(cyc_start === 1'b1, "R8", {tag, " strobe at start"}, int'(cyc_start), 1);
    check(int'(cyc_kind) == cur, "R8", {tag, " cyc_kind"}, int'(cyc_kind), cur);
    case (cur)
      1: exp_hi = 8;
      2: begin
        m = k0 + 5;
        while ((m % 14) != 7) m++;
        exp_hi = 3 + (m - k0 - 5) + 7;
      end
      default: exp_hi = 3;
    endcase
    cyc_req = next_req;
    pend_kind = dec(next_req);
    sv = '0;
    lo = 1;
    step();
    check(cyc_start === 1'b0, "R8", {tag, " strobe one cycle"}, int'(cyc_start), 0);
    while (!fast_clk && lo < 40) begin lo++; step(); end
    hi = 0;
    while (!cyc_start && hi < 40) begin
      sv[hi] = slow_clk;
      hi++;
      step();
    end
    check(lo == 2, cur == 1 ? "R5" : (cur == 2 ? "R6" : "R4"),
          {tag, " low length"}, lo, 2);
    check(hi == exp_hi, cur == 1 ? "R5" : (cur == 2 ? "R6" : "R4"),
          {tag, " high length"}, hi, exp_hi);
    if (cur == 2 && hi >= 8) begin
      check(sv[hi-8] === 1'b0, "R6", {tag, " slow low before lock"}, int'(sv[hi-8]), 0);
      for (int i = hi - 7; i < hi; i++)
        check(sv[i] === 1'b1, "R6", {tag, " slow high while locked"}, int'(sv[i]), 1);
      check(slow_clk === 1'b0, "R6", {tag, " slow falls with fast"}, int'(slow_clk), 0);
    end
  endtask

  task automatic t_reset_first_normal();
    do_reset(2'b10);
    run_cycle(2'b00, "R10 first cycle");
  endtask

  task automatic t_normal_refresh();
    run_cycle(2'b01, "R4 normal");
    run_cycle(2'b11, "R5 refresh");
  endtask

  task automatic t_reserved();
    run_cycle(2'b10, "R9 reserved code");
  endtask

  task automatic t_sync_mid();
    run_cycle(2'b00, "R6 sync ext5");
  endtask

  task automatic t_sync_zero();
    for (int i = 0; i < 5; i++) run_cycle(2'b00, "R4 pad");
    run_cycle(2'b10, "R4 pad");
    check((k % 14) == 2, "R7", "start offset", k % 14, 2);
    run_cycle(2'b00, "R7 sync zero ext");
  endtask

  task automatic t_sync_max();
    for (int i = 0; i < 8; i++) run_cycle(2'b00, "R4 pad");
    run_cycle(2'b10, "R4 pad");
    run_cycle(2'b00, "R6 sync ext13");
  endtask

  task automatic t_sync_slow_high();
    run_cycle(2'b10, "R4 pad");
    check(slow_clk === 1'b0, "R6", "slow low at sync start", int'(slow_clk), 0);
    run_cycle(2'b00, "R6 sync from high");
  endtask

  task automatic t_reset_mid();
    step(); step(); step();
    do_reset(2'b01);
    run_cycle(2'b01, "R10 after mid reset");
    run_cycle(2'b00, "R5 refresh after reset");
  endtask

  initial begin
    t_reset_first_normal();
    t_normal_refresh();
    t_reserved();
    t_sync_mid();
    t_sync_zero();
    t_sync_max();
    t_sync_slow_high();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule